// File: doc/BRIEF.md
# Programmable Acknowledge Wait-State Generator

This block is slave-side glue for an asynchronous, strobe-based bus. It produces the active-low transfer acknowledge that ends a bus cycle. An external address decoder supplies a set of region-select lines. Each region has its own programmable wait count. When the address strobe is low and either data strobe is low, the block counts clocks in a shift register. When the tap for the selected region's count is reached, it drives acknowledge low.

A region with a count of zero acknowledges on the first clock that sees the strobes. This gives the no-wait behaviour of a bus whose acknowledge is always asserted. A larger count stretches the cycle for slow devices. The delay starts from the data strobes, not the address strobe. A read-modify-write cycle keeps the address strobe low across both halves, so each half is timed separately. When the data strobes go away, the chain is cleared and acknowledge returns high on the next clock.

Accesses flagged as peripheral-address cycles are never acknowledged. When no region is selected, the output enable is low so another slave can drive acknowledge. A one-clock pulse marks every completed acknowledged access.

Top module: `ackgen_waitstate`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `ack_n` to 1, `ack_oe` to 0 and `done_pulse` to 0. The same edge clears the delay chain and loads every wait count from `RESET_WAITS`.
- R2: An access is active at an edge when `as_n` is 0 and at least one of `uds_n`/`lds_n` is 0. For a selected region whose wait count is 0, `ack_n` is 0 after the first active edge.
- R3: For a wait count w, `ack_n` falls after the (w+1)-th consecutive active edge. Before that, it stays 1.
- R4: Either data strobe alone starts the count. The address strobe without a data strobe starts nothing, and `ack_n` stays 1.
- R5: At the first edge where the access is not active, `ack_n` returns to 1 and the chain clears. A following access counts its full wait again.
- R6: At any edge where `vpa_n` is 0, `ack_n` is set to 1, whatever the region or count.
- R7: `ack_oe` follows the OR of `region_sel` with one clock of delay. With no region selected, `ack_n` stays 1.
- R8: When several bits of `region_sel` are set, the lowest-numbered selected region supplies the wait count.
- R9: An edge with `cfg_we` = 1 loads region i's count from `cfg_wdata[3i+2:3i]`. The new count applies from the next edge.
- R10: `done_pulse` is 1 for exactly one clock. It is set at the edge where an access ends while `ack_n` is 0.
- R11: Once `ack_n` is 0, it stays 0 while the access stays active, a region stays selected and `vpa_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| vpa_n | input | 1 | Peripheral-address cycle flag, active low; blocks acknowledge |
| region_sel | input | N_REG | Region selects from the address decoder |
| cfg_we | input | 1 | Load enable for the wait-count register |
| cfg_wdata | input | N_REG*WAIT_W | Packed wait counts, region 0 in the low bits |
| ack_n | output | 1 | Registered transfer acknowledge, active low |
| ack_oe | output | 1 | Output enable for acknowledge (a region is selected) |
| done_pulse | output | 1 | One-clock pulse per completed acknowledged access |

## Verification
The bench builds the block with its default parameters: four regions and 3-bit counts. That puts every wait value from 0 up to the deepest tap of 7 within reach, as well as overlapping selects that exercise priority. A behavioural model counts consecutive active edges per access and is compared with all three outputs on every clock. Directed latency measurements pin the exact number of clocks for counts 0, 2, 5 and 7.

// File: rtl/ackgen_pkg.sv
package ackgen_pkg;
  // Output bundle produced by the acknowledge stage
  typedef struct packed {
    logic ack_n;
    logic ack_oe;
    logic done;
  } ack_out_t;

  localparam int unsigned ACKGEN_DEF_REGIONS = 4;
  localparam int unsigned ACKGEN_DEF_WAIT_W  = 3;
endpackage

// File: rtl/ackgen_region.sv
module ackgen_region #(
  parameter int unsigned N_REG  = 4,
  parameter int unsigned WAIT_W = 3,
  parameter logic [N_REG*WAIT_W-1:0] RESET_WAITS = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [N_REG*WAIT_W-1:0] cfg_wdata,
  input  logic [N_REG-1:0]        region_sel,
  output logic                    sel_any,
  output logic [WAIT_W-1:0]       sel_wait
);
  localparam int unsigned IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;

  logic [WAIT_W-1:0] waits [N_REG];
  logic [IDX_W-1:0]  sel_idx;

  // One count register per region
  generate
    for (genvar g = 0; g < N_REG; g++) begin : g_wait
      always_ff @(posedge clk) begin
        if (rst)         waits[g] <= RESET_WAITS[g*WAIT_W +: WAIT_W];
        else if (cfg_we) waits[g] <= cfg_wdata[g*WAIT_W +: WAIT_W];
      end
    end
  endgenerate

  // Lowest-numbered selected region wins
  always_comb begin
    sel_idx = '0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (region_sel[i]) sel_idx = IDX_W'(i);
    end
  end

  assign sel_any  = |region_sel;
  assign sel_wait = waits[sel_idx];

  // R8
  prio_low_chk: assert property (@(posedge clk) disable iff (rst)
    (region_sel[0] && !$past(cfg_we) && !$past(rst)) |-> (sel_wait == $past(waits[0])));
endmodule

// File: rtl/ackgen_chain.sv
module ackgen_chain #(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ds_act,
  input  logic [WAIT_W-1:0] sel_wait,
  output logic              ready
);
  localparam int unsigned TAPS = (1 << WAIT_W) - 1;

  logic [TAPS-1:0] sr;
  logic [TAPS:0]   taps;

  // Thermometer shift register: fills while strobes stay active
  always_ff @(posedge clk) begin
    if (rst || !ds_act) sr <= '0;
    else                sr <= {sr[TAPS-2:0], 1'b1};
  end

  assign taps  = {sr, ds_act};
  assign ready = ds_act & taps[sel_wait];

  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_act && $past(ds_act) && $past(ready) && $stable(sel_wait)) |-> ready);
endmodule

// File: rtl/ackgen_out.sv
module ackgen_out
  import ackgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ds_act,
  input  logic     sel_any,
  input  logic     vpa_n,
  input  logic     ready,
  output ack_out_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q.ack_n  <= 1'b1;
      q.ack_oe <= 1'b0;
      q.done   <= 1'b0;
    end else begin
      q.ack_n  <= ~(ds_act & sel_any & vpa_n & ready);
      q.ack_oe <= sel_any;
      q.done   <= ~q.ack_n & ~ds_act;
    end
  end

  // R6
  vpa_block_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(vpa_n) |-> q.ack_n);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ds_act) |-> q.ack_n);

  // R7
  nosel_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_any) |-> (q.ack_n && !q.ack_oe));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    q.done |=> !q.done);
endmodule

// File: rtl/ackgen_waitstate.sv
module ackgen_waitstate
  import ackgen_pkg::*;
#(
  parameter int unsigned N_REG  = ACKGEN_DEF_REGIONS,
  parameter int unsigned WAIT_W = ACKGEN_DEF_WAIT_W,
  parameter logic [N_REG*WAIT_W-1:0] RESET_WAITS = {N_REG{WAIT_W'(1)}}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    as_n,
  input  logic                    uds_n,
  input  logic                    lds_n,
  input  logic                    vpa_n,
  input  logic [N_REG-1:0]        region_sel,
  input  logic                    cfg_we,
  input  logic [N_REG*WAIT_W-1:0] cfg_wdata,
  output logic                    ack_n,
  output logic                    ack_oe,
  output logic                    done_pulse
);
  logic              ds_act;
  logic              sel_any;
  logic [WAIT_W-1:0] sel_wait;
  logic              ready;
  ack_out_t          oq;

  // Timing starts from a data strobe inside an address-strobe cycle
  assign ds_act = ~as_n & (~uds_n | ~lds_n);

  ackgen_region #(.N_REG(N_REG), .WAIT_W(WAIT_W), .RESET_WAITS(RESET_WAITS)) u_region (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .region_sel(region_sel), .sel_any(sel_any), .sel_wait(sel_wait));

  ackgen_chain #(.WAIT_W(WAIT_W)) u_chain (
    .clk(clk), .rst(rst), .ds_act(ds_act), .sel_wait(sel_wait), .ready(ready));

  ackgen_out u_out (
    .clk(clk), .rst(rst), .ds_act(ds_act), .sel_any(sel_any),
    .vpa_n(vpa_n), .ready(ready), .q(oq));

  assign ack_n      = oq.ack_n;
  assign ack_oe     = oq.ack_oe;
  assign done_pulse = oq.done;

  // R4
  as_only_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(uds_n) && $past(lds_n)) |-> ack_n);

  // R2
  zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ds_act) && $past(sel_any) && $past(vpa_n) && ($past(sel_wait) == '0)) |-> !ack_n);
endmodule

// File: tb/test_ackgen_waitstate.sv
module test_ackgen_waitstate;
  localparam int N_REG  = 4;
  localparam int WAIT_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, vpa_n = 1'b1;
  logic [N_REG-1:0] region_sel = '0;
  logic cfg_we = 1'b0;
  logic [N_REG*WAIT_W-1:0] cfg_wdata = '0;
  logic ack_n, ack_oe, done_pulse;

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";

  // behavioural model state
  int  m_wait [N_REG];
  int  m_cnt = 0;
  bit  m_ack_n = 1, m_oe = 0, m_done = 0;
  bit  started = 0;

  always #10 clk = ~clk;

  ackgen_waitstate #(.N_REG(N_REG), .WAIT_W(WAIT_W)) i_ackgen_waitstate (
    .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .vpa_n(vpa_n), .region_sel(region_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ack_n(ack_n), .ack_oe(ack_oe), .done_pulse(done_pulse));

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Model: advances on each edge from the inputs held since the previous falling edge
  always @(posedge clk) begin
    bit act, any, ready;
    int w;
    started = 1;
    if (rst) begin
      m_ack_n = 1; m_oe = 0; m_done = 0; m_cnt = 0;
      for (int i = 0; i < N_REG; i++) m_wait[i] = 1;
    end else begin
      act = !as_n && (!uds_n || !lds_n);
      any = |region_sel;
      w = 0;
      for (int i = N_REG - 1; i >= 0; i--) if (region_sel[i]) w = m_wait[i];
      ready = act && (m_cnt >= w);
      m_done  = act ? 0 : !m_ack_n;
      m_ack_n = !(act && any && vpa_n && ready);
      m_oe    = any;
      m_cnt   = act ? ((m_cnt < 100) ? m_cnt + 1 : m_cnt) : 0;
      if (cfg_we)
        for (int i = 0; i < N_REG; i++) m_wait[i] = int'(cfg_wdata[i*WAIT_W +: WAIT_W]);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(tag, ack_n, m_ack_n, "ack_n");
      check(tag, ack_oe, m_oe, "ack_oe");
      check(tag, done_pulse, m_done, "done_pulse");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive one access, hold strobes for 'hold' cycles, then release
  task automatic access(logic [N_REG-1:0] sel, logic u, logic l, int hold);
    @(negedge clk);
    region_sel = sel; as_n = 0; uds_n = u; lds_n = l;
    idle(hold);
    as_n = 1; uds_n = 1; lds_n = 1;
    idle(1);
    region_sel = '0;
    idle(2);
  endtask

  // Count falling edges from strobe assertion until ack_n is seen low
  task automatic latency(string req, logic [N_REG-1:0] sel, int exp);
    int n = 0;
    @(negedge clk);
    region_sel = sel; as_n = 0; uds_n = 0; lds_n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n++;
      if (!ack_n) break;
    end
    check(req, n, exp, "latency");
    as_n = 1; uds_n = 1; lds_n = 1;
    @(negedge clk);
    check("R5", ack_n, 1, "release after one edge");
    check("R10", done_pulse, 1, "done pulse");
    region_sel = '0;
    idle(2);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    check("R1", ack_n, 1, "reset ack_n");
    check("R1", ack_oe, 0, "reset ack_oe");
    check("R1", done_pulse, 0, "reset done");
    rst = 0;
    idle(1);
    // reset counts are 1 each
    tag = "R3"; latency("R3", 4'b0001, 2);

    tag = "R9";
    @(negedge clk);
    cfg_we = 1; cfg_wdata = {3'd7, 3'd5, 3'd2, 3'd0};
    @(negedge clk);
    cfg_we = 0;
    idle(1);

    tag = "R2"; latency("R2", 4'b0001, 1);
    access(4'b0001, 0, 1, 4);
    tag = "R3";
    latency("R3", 4'b0010, 3);
    latency("R3", 4'b0100, 6);
    latency("R3", 4'b1000, 8);
    access(4'b1000, 0, 0, 5);          // too short: no ack
    access(4'b0010, 0, 0, 10);

    tag = "R4";
    access(4'b0010, 0, 1, 5);          // upper only
    access(4'b0010, 1, 0, 5);          // lower only
    @(negedge clk);
    region_sel = 4'b0001; as_n = 0;    // address strobe only
    idle(4);
    check("R4", ack_n, 1, "no ack without data strobe");
    as_n = 1; region_sel = '0;
    idle(2);

    tag = "R5";
    @(negedge clk);
    region_sel = 4'b0010; as_n = 0; uds_n = 0; lds_n = 0;
    idle(4);
    uds_n = 1; lds_n = 1;              // as held low: second half of a read-modify-write
    idle(1);
    check("R5", ack_n, 1, "ack released between halves");
    uds_n = 0;
    idle(2);
    check("R5", ack_n, 1, "second half recounts");
    idle(1);
    check("R5", ack_n, 0, "second half acknowledged");
    as_n = 1; uds_n = 1; region_sel = '0;
    idle(3);

    tag = "R6";
    vpa_n = 0;
    access(4'b0001, 0, 0, 4);
    vpa_n = 1;
    @(negedge clk);
    region_sel = 4'b0001; as_n = 0; lds_n = 0;
    idle(2);
    vpa_n = 0;
    idle(1);
    check("R6", ack_n, 1, "vpa removes ack");
    vpa_n = 1;
    idle(1);
    as_n = 1; lds_n = 1; region_sel = '0;
    idle(2);

    tag = "R7";
    access(4'b0000, 0, 0, 6);

    tag = "R8";
    latency("R8", 4'b1100, 6);
    latency("R8", 4'b1011, 1);

    tag = "R10"; access(4'b0100, 0, 0, 7);
    tag = "R11"; access(4'b0010, 0, 0, 12);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule